// File: doc/BRIEF.md
# Bidirectional GPIO port with pull-ups

This block is an 8-bit general-purpose I/O port with a small register bus. Its three registers are a direction mask, an output-data latch and a read-only view of the synchronized pin levels. For each pin it gives an external pad model three signals: a drive value, a drive enable and a pull-up enable.

The output-data latch has two jobs. On a pin set as output, its bit is the level the pin drives. On a pin set as input, its bit requests that pin's pull-up. A global pull-up disable input overrides every pull-up request at once. The pad levels pass through a two-flop synchronizer before the bus can read them. Software can therefore read both the latch and the real pin state, and can tell the two apart.

Top module: `gpio_port`

## Requirements
- R1: During and after reset, the direction and output-data registers are 0. Every pin is an input, with `pad_oe`, `pad_out` and `pad_pu` all 0. Reads at offsets 0, 1 and 2 return 0 while reset is held.
- R2: A write at offset 0 loads the direction register. A 1 bit makes that pin an output and a 0 bit makes it an input. `pad_oe` equals the register, and a read at offset 0 returns it.
- R3: For a pin whose direction bit is 1, `pad_out` carries that pin's output-data bit. For a pin whose direction bit is 0, `pad_out` is 0.
- R4: `pad_pu` is 1 for a pin only when its direction bit is 0, its output-data bit is 1 and `pull_disable` is 0. A pin that is an output never has its pull-up on.
- R5: While `pull_disable` is 1, every bit of `pad_pu` is 0 in the same cycle, whatever the registers hold. The registers themselves keep their contents.
- R6: A write at offset 1 loads the output-data register. A read at offset 1 returns the latched value, not the pin levels.
- R7: A read at offset 2 returns `pad_in` as sampled two rising clock edges earlier. A change on `pad_in` first becomes visible after the second rising edge.
- R8: Writes at offset 2 and offset 3 change no register. A read at offset 3 returns 0.
- R9: A write takes effect at the rising edge where `bus_we` is 1. With `bus_we` at 0, no register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 direction, 1 output data, 2 pin input |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset (combinational) |
| pull_disable | input | 1 | Global override that forces every pull-up off |
| pad_in | input | 8 | Levels seen at the pads (asynchronous) |
| pad_out | output | 8 | Drive value for each pad |
| pad_oe | output | 8 | Drive enable for each pad |
| pad_pu | output | 8 | Pull-up enable for each pad |

## Verification
The pad controls are combinational functions of the two latches and the global disable. A corrupted direction or output-data bit therefore shows up on `pad_oe`, `pad_out` or `pad_pu` in the cycle after the faulty write, and on the readback of that offset in the same cycle. A synchronizer with the wrong depth or a stuck stage shows up as a readback at offset 2 that arrives one edge early or late, or never changes. The bench sweeps all 256 direction masks against varying data with the disable both low and high, and checks the pin path edge by edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_ADDR_W = 2;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    RSEL_DIR  = 2'd0,
    RSEL_OUT  = 2'd1,
    RSEL_PIN  = 2'd2,
    RSEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GPIO_ADDR_W-1:0] bus_addr,
  input  logic                   bus_we,
  input  logic [WIDTH-1:0]       bus_wdata,
  input  logic [WIDTH-1:0]       pin_sync,
  output logic [WIDTH-1:0]       bus_rdata,
  output logic [WIDTH-1:0]       dir_q,
  output logic [WIDTH-1:0]       dout_q,
  output logic                   wr_dir,
  output logic                   wr_dout,
  output logic                   wr_dropped
);
  // named write events, brought out for the checker
  assign wr_dir     = bus_we && (bus_addr == RSEL_DIR);
  assign wr_dout    = bus_we && (bus_addr == RSEL_OUT);
  assign wr_dropped = bus_we && !wr_dir && !wr_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      if (wr_dir)  dir_q  <= bus_wdata;
      if (wr_dout) dout_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      RSEL_DIR: bus_rdata = dir_q;
      RSEL_OUT: bus_rdata = dout_q;
      RSEL_PIN: bus_rdata = pin_sync;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] dout_q,
  input  logic             pull_disable,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  // drive only where the pin is an output
  function automatic logic [WIDTH-1:0] drive_value(
    input logic [WIDTH-1:0] dir, input logic [WIDTH-1:0] dat);
    return dir & dat;
  endfunction

  // pull-up request on input pins, cleared by the global override
  function automatic logic [WIDTH-1:0] pull_mask(
    input logic [WIDTH-1:0] dir, input logic [WIDTH-1:0] dat, input logic off);
    return off ? '0 : (~dir & dat);
  endfunction

  assign pad_oe  = dir_q;
  assign pad_out = drive_value(dir_q, dout_q);
  assign pad_pu  = pull_mask(dir_q, dout_q, pull_disable);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GPIO_ADDR_W-1:0] bus_addr,
  input  logic                   bus_we,
  input  logic [WIDTH-1:0]       bus_wdata,
  output logic [WIDTH-1:0]       bus_rdata,
  input  logic                   pull_disable,
  input  logic [WIDTH-1:0]       pad_in,
  output logic [WIDTH-1:0]       pad_out,
  output logic [WIDTH-1:0]       pad_oe,
  output logic [WIDTH-1:0]       pad_pu
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] dout_q;
  logic             wr_dir;
  logic             wr_dout;
  logic             wr_dropped;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .pin_sync   (pin_sync),
    .bus_rdata  (bus_rdata),
    .dir_q      (dir_q),
    .dout_q     (dout_q),
    .wr_dir     (wr_dir),
    .wr_dout    (wr_dout),
    .wr_dropped (wr_dropped)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .dir_q        (dir_q),
    .dout_q       (dout_q),
    .pull_disable (pull_disable),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .pad_pu       (pad_pu)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [GPIO_ADDR_W-1:0] bus_addr,
  input logic                   bus_we,
  input logic [WIDTH-1:0]       bus_wdata,
  input logic [WIDTH-1:0]       bus_rdata,
  input logic                   pull_disable,
  input logic [WIDTH-1:0]       pad_in,
  input logic [WIDTH-1:0]       pad_out,
  input logic [WIDTH-1:0]       pad_oe,
  input logic [WIDTH-1:0]       pad_pu,
  input logic                   wr_dropped
);
  logic [1:0] live_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 live_cycles <= '0;
    else if (live_cycles != 2'd3) live_cycles <= live_cycles + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (pad_oe == '0 && pad_out == '0 && pad_pu == '0)
        else $error("R1 pads not idle in reset");
    end
  end

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RSEL_DIR) |=> pad_oe == $past(bus_wdata));

  assert_no_drive_on_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  assert_no_pull_on_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  assert_global_pull_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pull_disable |-> pad_pu == '0);

  assert_pin_two_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == RSEL_PIN && live_cycles >= 2'd2) |-> bus_rdata == $past(pad_in, 2));

  assert_dropped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> ($stable(pad_oe) && $stable(pad_out)));

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .pull_disable (pull_disable),
  .pad_in       (pad_in),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .pad_pu       (pad_pu),
  .wr_dropped   (wr_dropped)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pull_disable = 1'b0;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pull_disable(pull_disable),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = ~d;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] exp_pu;
    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    bus_read(2'd0, rd); check("R1 dir read", rd, 8'h00);
    bus_read(2'd1, rd); check("R1 out read", rd, 8'h00);
    bus_read(2'd2, rd); check("R1 pin read", rd, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R6: sweep every direction mask
    for (int i = 0; i < 256; i++) begin
      logic [7:0] dv, ov;
      dv = i[7:0];
      ov = (i[7:0] * 8'd37) ^ 8'h5A;
      bus_write(2'd0, dv);
      bus_write(2'd1, ov);
      pull_disable = 1'b0;
      #0.5;
      check("R2 pad_oe", pad_oe, dv);
      check("R3 pad_out", pad_out, ov & dv);
      exp_pu = ov & ~dv;
      check("R4 pad_pu", pad_pu, exp_pu);
      bus_read(2'd0, rd); check("R2 dir read", rd, dv);
      bus_read(2'd1, rd); check("R6 out read", rd, ov);
      pull_disable = 1'b1;
      #0.5;
      check("R5 pad_pu forced off", pad_pu, 8'h00);
      bus_read(2'd1, rd); check("R5 latch kept", rd, ov);
      pull_disable = 1'b0;
      #0.5;
      check("R5 pad_pu restored", pad_pu, exp_pu);
    end

    // R6: latch differs from pin levels
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'hFF);
    @(negedge clk); pad_in = 8'h0F;
    repeat (3) @(negedge clk);
    bus_read(2'd1, rd); check("R6 latch not pins", rd, 8'hFF);
    bus_read(2'd2, rd); check("R6 pins view", rd, 8'h0F);

    // R7: two-edge latency for several patterns
    for (int k = 0; k < 6; k++) begin
      logic [7:0] prev, nv;
      prev = pad_in;
      nv = 8'h11 * k[7:0] ^ 8'hC3;
      @(negedge clk); pad_in = nv;
      bus_read(2'd2, rd); check("R7 before edge", rd, prev);
      @(negedge clk);
      bus_read(2'd2, rd); check("R7 after one edge", rd, prev);
      @(negedge clk);
      bus_read(2'd2, rd); check("R7 after two edges", rd, nv);
    end

    // R8: writes at offsets 2 and 3 are dropped
    bus_write(2'd0, 8'h3C);
    bus_write(2'd1, 8'h96);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    #0.5;
    check("R8 pad_oe kept", pad_oe, 8'h3C);
    check("R8 pad_out kept", pad_out, 8'h96 & 8'h3C);
    check("R8 pad_pu kept", pad_pu, 8'h96 & ~8'h3C);
    bus_read(2'd0, rd); check("R8 dir kept", rd, 8'h3C);
    bus_read(2'd1, rd); check("R8 out kept", rd, 8'h96);
    bus_read(2'd3, rd); check("R8 offset3 reads 0", rd, 8'h00);

    // R9: no write without strobe, on either register offset
    for (int a = 0; a < 2; a++) begin
      @(negedge clk);
      bus_addr = a[1:0]; bus_we = 1'b0; bus_wdata = 8'hE1;
      @(negedge clk);
      #0.5;
      check("R9 pad_oe idle", pad_oe, 8'h3C);
      bus_read(2'd1, rd); check("R9 out idle", rd, 8'h96);
    end

    // R9: a write lands at the strobed edge, not before
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 8'hF0;
    #0.5;
    check("R9 before edge", pad_oe, 8'h3C);
    @(negedge clk); bus_we = 1'b0;
    check("R9 after edge", pad_oe, 8'hF0);

    finish_run();
  end
endmodule